// File: doc/BRIEF.md
# SPI TPM Register Transaction Sequencer

This block is the host side of a SPI link to a TPM-style device. It carries out one register access per request, either a read or a write of 1 to 64 bytes at a 16-bit register offset. Each access has three phases. First comes a four-byte command header. Next comes a wait loop in which single bytes are clocked until the device reports that it is ready. Last comes the payload. Chip select is held low from the first header bit until the last payload bit.

A request is taken only while an external pacing gate is high. That gate is where spacing between transactions and device wake-up are handled. A length outside the legal range is refused at once, with an invalid-argument code and no bus activity. If the device does not report ready before a timeout, counted in system clock cycles, the access ends with a busy code. Write data is fetched from a buffer owned by the requester through an index/byte port. Read bytes are returned one at a time with their index. Every accepted request ends with a one-cycle done pulse that carries an error code.

Top module: `spi_tpm_seq`

## Requirements
- R1: Header byte 0 carries the direction in bit 7 (1 = read, 0 = write) and the length minus one in bits 6:0.
- R2: Header byte 1 is 0xD4. Header bytes 2 and 3 are the high and low bytes of the register offset. Every byte is shifted most-significant bit first.
- R3: A length of 0 or above 64 finishes with err_o = 1 (invalid) and a done pulse, and chip select is never asserted.
- R4: After the header, the sequencer sends 0x00 bytes one at a time and stops polling after the first received byte whose bit 0 is 1.
- R5: Bit 0 of the bytes received during the header is ignored, so polling always follows the header.
- R6: If readiness is not seen within the timeout, the access ends with err_o = 2 (busy), chip select is released, and no payload byte is transferred.
- R7: Chip select falls once per accepted access and rises only at its end, together with the done pulse.
- R8: In a write, payload byte k is requested on wr_idx_o = k and shifted out on MOSI in increasing index order.
- R9: In a read, each received payload byte is presented on rd_byte_o with its index on rd_idx_o for one cycle of rd_valid_o.
- R10: SPI mode 0 is used. SCLK is low whenever chip select is high, and MOSI does not change in the cycle in which SCLK rises.
- R11: start_i has no effect while gate_i is low.
- R12: done_o is a single-cycle pulse for each accepted request, with err_o = 0 on success. After reset chip select is high, SCLK is low and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | Pacing gate; a request is accepted only while it is high |
| start_i | input | 1 | Request strobe |
| rd_i | input | 1 | 1 = read, 0 = write |
| len_i | input | 7 | Payload length in bytes (legal range 1 to 64) |
| addr_i | input | 16 | Register offset |
| wr_idx_o | output | 6 | Index of the write byte being fetched |
| wr_byte_i | input | 8 | Write byte at wr_idx_o |
| rd_valid_o | output | 1 | Read byte strobe |
| rd_idx_o | output | 6 | Index of the returned read byte |
| rd_byte_o | output | 8 | Returned read byte |
| done_o | output | 1 | End-of-access pulse |
| err_o | output | 2 | 0 ok, 1 invalid length, 2 busy timeout; valid with done_o |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Data to the device |
| miso_i | input | 1 | Data from the device |

## Verification
The cases that are hardest to reach from the ports are a device that reports ready during the header and a device that never reports ready. The bench's device model answers every header byte with bit 0 set, so a sequencer that checks readiness too early would skip the poll loop and change the total byte count. The model also takes a programmable number of not-ready poll replies, 0xFE, which has every bit set except bit 0. Setting that number far past the timeout forces the busy path, while the bench confirms that no payload byte is returned and that chip select rises once.

// File: rtl/spi_tpm_pkg.sv
package spi_tpm_pkg;
  localparam logic [1:0] ERR_OK    = 2'd0;
  localparam logic [1:0] ERR_INVAL = 2'd1;
  localparam logic [1:0] ERR_BUSY  = 2'd2;
  localparam logic [7:0] HDR_TAG   = 8'hD4;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_POLL, ST_DATA} seq_state_e;

  function automatic logic [7:0] hdr_byte(logic rd, logic [6:0] len_m1,
                                          logic [15:0] addr, logic [1:0] sel);
    case (sel)
      2'd0:    return {rd, len_m1};
      2'd1:    return HDR_TAG;
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy   <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx_o   <= '0;
      sclk_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy) begin
        busy   <= 1'b1;
        sh     <= tx_i;
        cnt    <= '0;
        bitn   <= '0;
        sclk_o <= 1'b0;
      end else if (busy) begin
        if (cnt == CW'(DIV - 1)) begin
          cnt <= '0;
          if (!sclk_o) begin
            sclk_o <= 1'b1;
            rx_o   <= {rx_o[6:0], miso_i};
          end else begin
            sclk_o <= 1'b0;
            if (bitn == 3'd7) begin
              busy   <= 1'b0;
              done_o <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign mosi_o = sh[7];

  // R4: one byte at a time, never relaunched mid-byte
  p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy);
  p_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sclk_o);
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int TMO = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int TW = $clog2(TMO + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= '0;
    else if (clr_i)             cnt <= '0;
    else if (cnt != TW'(TMO))   cnt <= cnt + TW'(1);
  end

  assign expired_o = (cnt == TW'(TMO));

  p_tmo_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o);
endmodule

// File: rtl/spi_tpm_seq.sv
module spi_tpm_seq
  import spi_tpm_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int MAX_LEN = 64,
  parameter int TMO     = 4096,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int IW = $clog2(MAX_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [LW-1:0] len_i,
  input  logic [15:0]   addr_i,
  output logic [IW-1:0] wr_idx_o,
  input  logic [7:0]    wr_byte_i,
  output logic          rd_valid_o,
  output logic [IW-1:0] rd_idx_o,
  output logic [7:0]    rd_byte_o,
  output logic          done_o,
  output logic [1:0]    err_o,
  output logic          sclk_o,
  output logic          cs_no,
  output logic          mosi_o,
  input  logic          miso_i
);
  seq_state_e    state;
  logic [IW-1:0] idx;
  logic          rd_q, launch, eng_start, eng_done, tmo;
  logic [LW-1:0] len_q;
  logic [15:0]   addr_q;
  logic [7:0]    eng_tx, eng_rx, tx_sel;
  logic [6:0]    len_m1;

  assign len_m1   = 7'(len_q - LW'(1));
  assign wr_idx_o = idx;

  always_comb begin
    case (state)
      ST_HDR:  tx_sel = hdr_byte(rd_q, len_m1, addr_q, idx[1:0]);
      ST_DATA: tx_sel = rd_q ? 8'h00 : wr_byte_i;
      default: tx_sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      idx        <= '0;
      rd_q       <= 1'b0;
      len_q      <= '0;
      addr_q     <= '0;
      launch     <= 1'b0;
      eng_start  <= 1'b0;
      eng_tx     <= '0;
      cs_no      <= 1'b1;
      done_o     <= 1'b0;
      err_o      <= ERR_OK;
      rd_valid_o <= 1'b0;
      rd_idx_o   <= '0;
      rd_byte_o  <= '0;
    end else begin
      launch     <= 1'b0;
      eng_start  <= launch;
      done_o     <= 1'b0;
      rd_valid_o <= 1'b0;
      if (launch) eng_tx <= tx_sel;
      case (state)
        ST_IDLE: if (start_i && gate_i) begin
          if (len_i == '0 || len_i > LW'(MAX_LEN)) begin
            done_o <= 1'b1;
            err_o  <= ERR_INVAL;
          end else begin
            rd_q   <= rd_i;
            len_q  <= len_i;
            addr_q <= addr_i;
            idx    <= '0;
            cs_no  <= 1'b0;
            state  <= ST_HDR;
            launch <= 1'b1;
          end
        end
        ST_HDR: if (eng_done) begin
          launch <= 1'b1;
          if (idx == IW'(3)) begin
            idx   <= '0;
            state <= ST_POLL;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        ST_POLL: if (eng_done) begin
          if (eng_rx[0]) begin
            state  <= ST_DATA;
            launch <= 1'b1;
          end else if (tmo) begin
            state  <= ST_IDLE;
            cs_no  <= 1'b1;
            done_o <= 1'b1;
            err_o  <= ERR_BUSY;
          end else begin
            launch <= 1'b1;
          end
        end
        ST_DATA: if (eng_done) begin
          if (rd_q) begin
            rd_valid_o <= 1'b1;
            rd_idx_o   <= idx;
            rd_byte_o  <= eng_rx;
          end
          if (idx == IW'(len_q - LW'(1))) begin
            state  <= ST_IDLE;
            cs_no  <= 1'b1;
            done_o <= 1'b1;
            err_o  <= ERR_OK;
          end else begin
            idx    <= idx + IW'(1);
            launch <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  spi_byte_engine #(.DIV(DIV)) u_eng (
    .clk_i, .rst_ni,
    .start_i (eng_start),
    .tx_i    (eng_tx),
    .miso_i,
    .sclk_o,
    .mosi_o,
    .done_o  (eng_done),
    .rx_o    (eng_rx)
  );

  poll_timer #(.TMO(TMO)) u_tmr (
    .clk_i, .rst_ni,
    .clr_i     (state != ST_POLL),
    .expired_o (tmo)
  );

  p_sclk_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_mosi_setup_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
  p_cs_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);
  p_inval_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == ERR_INVAL) |-> (cs_no && $past(cs_no)));
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_rd_in_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!cs_no || done_o));
endmodule

// File: tb/sim_spi_tpm_seq.sv
module sim_spi_tpm_seq;
  localparam int DIV = 2;
  localparam int TMO = 1500;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic gate = 1'b0, start = 1'b0, rd = 1'b0;
  logic [6:0] len = '0;
  logic [15:0] addr = '0;
  logic [5:0] wr_idx, rd_idx;
  logic [7:0] wr_byte, rd_byte;
  logic rd_valid, done, sclk, cs_n, mosi, miso = 1'b0;
  logic [1:0] err;

  int n_chk = 0, n_fail = 0;
  int wait_n = 0, bitcnt = 0, nbytes = 0;
  int cs_falls = 0, cs_rises = 0, done_cnt = 0, rd_cnt = 0;
  logic [1:0] last_err;
  logic [7:0] shin;
  logic [7:0] dev_bytes [256];
  logic [7:0] rd_got [64];
  logic [7:0] wr_mem [64];

  always #10 clk = ~clk;

  spi_tpm_seq #(.DIV(DIV), .MAX_LEN(64), .TMO(TMO)) u0 (
    .clk_i(clk), .rst_ni, .gate_i(gate), .start_i(start), .rd_i(rd),
    .len_i(len), .addr_i(addr), .wr_idx_o(wr_idx), .wr_byte_i(wr_byte),
    .rd_valid_o(rd_valid), .rd_idx_o(rd_idx), .rd_byte_o(rd_byte),
    .done_o(done), .err_o(err), .sclk_o(sclk), .cs_no(cs_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  assign wr_byte = wr_mem[wr_idx];

  // Device model: header replies carry bit 0 set, then wait_n not-ready bytes.
  function automatic logic [7:0] resp(int i);
    if (i < 4)               return 8'h01;
    else if (i < 4 + wait_n) return 8'hFE;
    else if (i == 4 + wait_n) return 8'h01;
    else                     return 8'h5A ^ 8'(i - 5 - wait_n);
  endfunction

  task automatic upd_miso();
    logic [7:0] c;
    c = resp(bitcnt / 8);
    miso = c[7 - (bitcnt % 8)];
  endtask

  always @(negedge cs_n) begin
    cs_falls++;
    bitcnt = 0;
    upd_miso();
  end
  always @(posedge cs_n) cs_rises++;

  always @(posedge sclk) if (!cs_n) begin
    shin = {shin[6:0], mosi};
    bitcnt++;
    if (bitcnt % 8 == 0) begin
      if (bitcnt / 8 <= 256) dev_bytes[bitcnt/8 - 1] = shin;
      nbytes = bitcnt / 8;
    end
    upd_miso();
  end

  always @(negedge clk) begin
    if (rd_valid) begin
      rd_got[rd_idx] = rd_byte;
      rd_cnt++;
    end
    if (done) begin
      done_cnt++;
      last_err = err;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    cs_falls = 0; cs_rises = 0; done_cnt = 0; rd_cnt = 0; nbytes = 0;
    for (int i = 0; i < 64; i++) rd_got[i] = 8'hxx;
  endtask

  task automatic run(bit r, int l, logic [15:0] a, int w);
    wait_n = w;
    clear_counts();
    @(negedge clk);
    rd = r; len = 7'(l); addr = a; gate = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done_cnt > 0) break;
      @(negedge clk);
    end
    chk(done_cnt == 1, "R12 done pulse count", done_cnt, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cs_n === 1'b1, "R12 reset cs", int'(cs_n), 1);
    chk(sclk === 1'b0, "R12 reset sclk", int'(sclk), 0);
    chk(done === 1'b0, "R12 reset done", int'(done), 0);
  endtask

  task automatic t_write();
    run(1'b0, 4, 16'h0F12, 2);
    chk(dev_bytes[0] == 8'h03, "R1 write header byte0", dev_bytes[0], 8'h03);
    chk(dev_bytes[1] == 8'hD4, "R2 tag byte", dev_bytes[1], 8'hD4);
    chk(dev_bytes[2] == 8'h0F, "R2 offset high", dev_bytes[2], 8'h0F);
    chk(dev_bytes[3] == 8'h12, "R2 offset low", dev_bytes[3], 8'h12);
    chk(nbytes == 4 + 3 + 4, "R4 byte total with 2 waits", nbytes, 11);
    for (int k = 4; k < 7; k++)
      chk(dev_bytes[k] == 8'h00, "R4 poll mosi", dev_bytes[k], 0);
    for (int k = 0; k < 4; k++)
      chk(dev_bytes[7+k] == wr_mem[k], "R8 write payload", dev_bytes[7+k], wr_mem[k]);
    chk(last_err == 2'd0, "R12 ok code", last_err, 0);
    chk(cs_falls == 1 && cs_rises == 1, "R7 single cs frame", cs_falls*16+cs_rises, 8'h11);
    chk(rd_cnt == 0, "R9 no read strobes on write", rd_cnt, 0);
  endtask

  task automatic t_read_hdr_ready();
    run(1'b1, 5, 16'hA55A, 0);
    chk(dev_bytes[0] == 8'h84, "R1 read header byte0", dev_bytes[0], 8'h84);
    chk(nbytes == 4 + 1 + 5, "R5 poll follows header", nbytes, 10);
    chk(rd_cnt == 5, "R9 read strobe count", rd_cnt, 5);
    for (int k = 0; k < 5; k++)
      chk(rd_got[k] == (8'h5A ^ 8'(k)), "R9 read data", rd_got[k], 8'h5A ^ 8'(k));
    chk(cs_falls == 1 && cs_rises == 1, "R7 single cs frame", cs_falls*16+cs_rises, 8'h11);
  endtask

  task automatic t_read_max();
    run(1'b1, 64, 16'h0001, 3);
    chk(dev_bytes[0] == 8'hBF, "R1 max length header", dev_bytes[0], 8'hBF);
    chk(rd_cnt == 64, "R9 max read count", rd_cnt, 64);
    for (int k = 0; k < 64; k++)
      chk(rd_got[k] == (8'h5A ^ 8'(k)), "R9 max read data", rd_got[k], 8'h5A ^ 8'(k));
    chk(last_err == 2'd0, "R12 ok code", last_err, 0);
  endtask

  task automatic t_invalid();
    run(1'b1, 65, 16'h1234, 0);
    chk(last_err == 2'd1, "R3 len 65 code", last_err, 1);
    chk(cs_falls == 0, "R3 len 65 no bus", cs_falls, 0);
    run(1'b0, 0, 16'h1234, 0);
    chk(last_err == 2'd1, "R3 len 0 code", last_err, 1);
    chk(cs_falls == 0 && nbytes == 0, "R3 len 0 no bus", cs_falls, 0);
  endtask

  task automatic t_gate();
    clear_counts();
    @(negedge clk);
    gate = 1'b0; rd = 1'b1; len = 7'd2; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    chk(done_cnt == 0, "R11 gate low no done", done_cnt, 0);
    chk(cs_falls == 0, "R11 gate low no cs", cs_falls, 0);
  endtask

  task automatic t_timeout();
    run(1'b1, 4, 16'h0030, 100000);
    chk(last_err == 2'd2, "R6 busy code", last_err, 2);
    chk(rd_cnt == 0, "R6 no payload", rd_cnt, 0);
    chk(cs_n === 1'b1 && cs_rises == 1, "R6 cs released", cs_rises, 1);
    chk(nbytes > 4 + 10, "R6 polling ran", nbytes, 15);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) wr_mem[k] = 8'h3C + 8'(k * 7);
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_write();
    t_read_hdr_ready();
    t_read_max();
    t_invalid();
    t_gate();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule